// File: doc/BRIEF.md
# Bfloat16 Immediate Widening Unit

This execute-stage unit accepts a 32-bit instruction word whose 16-bit immediate is split across three separate fields. When the word carries the expected major and extended opcodes, the unit puts the immediate back together and reads it as a bfloat16 number. A bfloat16 is the upper half of a single-precision value, so the lower 16 bits are taken as zero. The unit then widens that value to IEEE double precision. One cycle later it presents the 64-bit result, the destination register index and a write strobe for the floating-point register file.

The conversion is exact. No rounding takes place and no status or exception flags are produced. Zeros, infinities and NaNs keep their sign, and NaNs keep their payload. Single-precision subnormals are normalized into the wider exponent range. Any instruction word with other opcodes is dropped, and the result outputs keep their last value.

Top module: `bf16_imm_widen`

## Requirements
- R1: Bits are numbered from 0 at the word MSB (vector bit 31). Major opcode is bits 0-5, destination is bits 6-10, immediate piece A is bits 11-15, piece B is bits 16-25, extended opcode is bits 26-30 and piece C is bit 31. The immediate is {B, A, C}, with B most significant.
- R2: An immediate of 0x0000 gives 0x0000_0000_0000_0000 and 0x8000 gives 0x8000_0000_0000_0000.
- R3: A normal input keeps its sign. Its double exponent is the 8-bit exponent (immediate bits 14:7) plus 896. The 7 immediate fraction bits fill the top of the 52-bit fraction, with zeros below. Examples: 0x3F80 gives 0x3FF0_0000_0000_0000, 0xBFC0 gives 0xBFF8_0000_0000_0000 and 0x3FFF gives 0x3FFF_E000_0000_0000.
- R4: An all-ones 8-bit exponent gives an all-ones 11-bit exponent with the fraction copied. Examples: 0x7F80 gives 0x7FF0_0000_0000_0000, 0xFF80 gives 0xFFF0_0000_0000_0000 and 0x7FC0 gives 0x7FF8_0000_0000_0000.
- R5: A zero exponent with a nonzero fraction is normalized. With k leading zeros in the 7-bit fraction, the exponent is 896-k and the remaining fraction bits are shifted up past the hidden one. Example: 0x0001 gives 0x37A0_0000_0000_0000.
- R6: A valid word with major opcode OPC_MAJOR (default 9) and extended opcode OPC_EXT (default 27) gives a write strobe, result and destination index on the clock edge that follows the input.
- R7: A word that is not valid, or that has any other major or extended opcode, gives no write strobe and leaves the result and destination outputs unchanged.
- R8: While reset is asserted, the write strobe, result and destination index are all zero.
- R9: Matching words on consecutive cycles each produce their own write strobe on consecutive cycles, with no gap and no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| out_wr | output | 1 | Register-file write strobe |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Double-precision result |

## Verification
A new instruction can be accepted in the same cycle that the previous result is on the outputs. A matching word can also be followed straight away by one that is rejected, so the output register must hold its value in one cycle and load in the next. The bench drives random streams with back-to-back matching words, near-miss opcodes and idle cycles mixed together. Every cycle it compares the strobe, the destination and the result against a reference computed one cycle earlier. In cycles without a write, it also checks that the result has not moved.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
   localparam int INSN_W   = 32;
   localparam int MAJOR_W  = 6;
   localparam int RD_W     = 5;
   localparam int PA_W     = 5;
   localparam int PB_W     = 10;
   localparam int XO_W     = 5;
   localparam int PC_W     = 1;
   localparam int IMM_W    = PB_W + PA_W + PC_W;

   // Vector positions derived from MSB-first field order
   localparam int MAJOR_LO = INSN_W - MAJOR_W;
   localparam int RD_LO    = MAJOR_LO - RD_W;
   localparam int PA_LO    = RD_LO - PA_W;
   localparam int PB_LO    = PA_LO - PB_W;
   localparam int XO_LO    = PB_LO - XO_W;
   localparam int PC_LO    = XO_LO - PC_W;

   typedef struct packed {
      logic [MAJOR_W-1:0] major;
      logic [XO_W-1:0]    xo;
      logic [RD_W-1:0]    rd;
      logic [IMM_W-1:0]   imm;
   } insn_fields_t;
endpackage

// File: rtl/bfw_field_unpack.sv
module bfw_field_unpack
   import bfw_pkg::*;
#(
   parameter logic [MAJOR_W-1:0] OPC_MAJOR = 6'd9,
   parameter logic [XO_W-1:0]    OPC_EXT   = 5'd27
) (
   input  logic [INSN_W-1:0] insn,
   output insn_fields_t      fields,
   output logic              match
);
   if (PC_LO != 0) begin : g_bad_layout
      $error("bfw_field_unpack: field widths do not cover the word");
   end

   always_comb begin
      fields.major = insn[MAJOR_LO +: MAJOR_W];
      fields.rd    = insn[RD_LO +: RD_W];
      fields.xo    = insn[XO_LO +: XO_W];
      fields.imm   = {insn[PB_LO +: PB_W], insn[PA_LO +: PA_W], insn[PC_LO +: PC_W]};
      match        = (fields.major == OPC_MAJOR) && (fields.xo == OPC_EXT);
   end
endmodule

// File: rtl/bfw_lzc.sv
module bfw_lzc #(
   parameter int W  = 7,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  val,
   output logic [CW-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("bfw_lzc: width must be positive");
   end

   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (val[i]) cnt = CW'(W - 1 - i);
      end
   end

   // R5
   always_comb begin
      if (|val) begin
         lz_lead_one_chk: assert ((val >> (W - 1 - int'(cnt))) == W'(1));
      end
   end
endmodule

// File: rtl/bfw_widen.sv
module bfw_widen #(
   parameter int IMM_W     = 16,
   parameter int S_EXP_W   = 8,
   parameter int D_EXP_W   = 11,
   parameter int D_FRAC_W  = 52,
   parameter bit NORM_SUB  = 1'b1,
   localparam int RES_W    = 1 + D_EXP_W + D_FRAC_W
) (
   input  logic [IMM_W-1:0] imm,
   output logic [RES_W-1:0] res
);
   localparam int FW      = IMM_W - 1 - S_EXP_W;
   localparam int S_BIAS  = (1 << (S_EXP_W - 1)) - 1;
   localparam int D_BIAS  = (1 << (D_EXP_W - 1)) - 1;
   localparam int REBIAS  = D_BIAS - S_BIAS;
   localparam int LZ_W    = $clog2(FW + 1);
   localparam int PAD_W   = D_FRAC_W - FW;

   if (FW < 1 || PAD_W < 0 || D_EXP_W <= S_EXP_W) begin : g_bad_fmt
      $error("bfw_widen: formats cannot be widened exactly");
   end

   logic                sgn;
   logic [S_EXP_W-1:0]  s_exp;
   logic [FW-1:0]       s_frac;
   logic [LZ_W-1:0]     lz;
   logic [D_EXP_W-1:0]  d_exp;
   logic [FW-1:0]       d_frac;
   logic [FW-1:0]       sub_frac;
   logic [D_EXP_W-1:0]  sub_exp;

   assign sgn    = imm[IMM_W-1];
   assign s_exp  = imm[FW +: S_EXP_W];
   assign s_frac = imm[FW-1:0];

   bfw_lzc #(.W(FW)) i_lzc (.val(s_frac), .cnt(lz));

   if (NORM_SUB) begin : g_norm
      logic [LZ_W:0] sh_amt;
      assign sh_amt   = {1'b0, lz} + {{LZ_W{1'b0}}, 1'b1};
      assign sub_frac = s_frac << sh_amt;
      assign sub_exp  = D_EXP_W'(REBIAS) - D_EXP_W'(lz);
   end else begin : g_flush
      assign sub_frac = '0;
      assign sub_exp  = '0;
   end

   always_comb begin
      if (s_exp == '1) begin
         d_exp  = '1;
         d_frac = s_frac;
      end else if (s_exp == '0) begin
         d_exp  = (s_frac == '0) ? '0 : sub_exp;
         d_frac = (s_frac == '0) ? '0 : sub_frac;
      end else begin
         d_exp  = D_EXP_W'(REBIAS) + D_EXP_W'(s_exp);
         d_frac = s_frac;
      end
   end

   assign res = {sgn, d_exp, d_frac, {PAD_W{1'b0}}};

   // R4
   always_comb begin
      if (s_exp == '1) begin
         special_exp_chk: assert (res[D_FRAC_W +: D_EXP_W] == '1);
      end
   end

   // R2
   always_comb begin
      if (imm[IMM_W-2:0] == '0) begin
         zero_mag_chk: assert (res[RES_W-2:0] == '0);
      end
   end
endmodule

// File: rtl/bf16_imm_widen.sv
module bf16_imm_widen
   import bfw_pkg::*;
#(
   parameter logic [MAJOR_W-1:0] OPC_MAJOR = 6'd9,
   parameter logic [XO_W-1:0]    OPC_EXT   = 5'd27,
   parameter int                 S_EXP_W   = 8,
   parameter int                 D_EXP_W   = 11,
   parameter int                 D_FRAC_W  = 52,
   parameter bit                 NORM_SUB  = 1'b1,
   localparam int                RES_W     = 1 + D_EXP_W + D_FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      in_insn,
   output logic             out_wr,
   output logic [4:0]       out_rd,
   output logic [RES_W-1:0] out_result
);
   if (RES_W != 64) begin : g_bad_res
      $error("bf16_imm_widen: result width must be 64");
   end

   insn_fields_t     fields;
   logic             match;
   logic [RES_W-1:0] widened;

   bfw_field_unpack #(
      .OPC_MAJOR(OPC_MAJOR),
      .OPC_EXT  (OPC_EXT)
   ) i_unpack (
      .insn  (in_insn),
      .fields(fields),
      .match (match)
   );

   bfw_widen #(
      .IMM_W   (IMM_W),
      .S_EXP_W (S_EXP_W),
      .D_EXP_W (D_EXP_W),
      .D_FRAC_W(D_FRAC_W),
      .NORM_SUB(NORM_SUB)
   ) i_widen (
      .imm(fields.imm),
      .res(widened)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_wr     <= 1'b0;
         out_rd     <= '0;
         out_result <= '0;
      end else begin
         out_wr <= in_valid && match;
         if (in_valid && match) begin
            out_rd     <= fields.rd;
            out_result <= widened;
         end
      end
   end

   // R6
   wr_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> $past(in_valid));

   // R6
   rd_follows_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> out_rd == $past(in_insn[25:21]));

   // R7
   opcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> ($past(in_insn[31:26]) == OPC_MAJOR && $past(in_insn[5:1]) == OPC_EXT));

   // R7
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_wr |-> ($stable(out_result) && $stable(out_rd)));
endmodule

// File: tb/test_bf16_imm_widen.sv
module test_bf16_imm_widen;
   localparam logic [5:0] MAJ = 6'd9;
   localparam logic [4:0] XO  = 5'd27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic        out_wr;
   logic [4:0]  out_rd;
   logic [63:0] out_result;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic        e_wr = 1'b0;
   logic [4:0]  e_rd = '0;
   logic [63:0] e_res = '0;
   string       e_tag = "R8";

   always #5 clk = ~clk;

   bf16_imm_widen i_bf16_imm_widen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .out_wr(out_wr), .out_rd(out_rd), .out_result(out_result)
   );

   function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] xo,
                                      input logic [4:0] rd, input logic [15:0] imm);
      // R1 field layout, MSB-first numbering
      return {maj, rd, imm[5:1], imm[15:6], xo, imm[0]};
   endfunction

   function automatic logic [63:0] ref_dbl(input logic [15:0] imm);
      logic [7:0]  e;
      logic [6:0]  f;
      logic [10:0] de;
      int          k;
      e = imm[14:7];
      f = imm[6:0];
      if (e == 8'hFF)      de = 11'h7FF;
      else if (e != 8'h00) de = 11'(e) + 11'd896;
      else if (f == 7'd0)  de = 11'd0;
      else begin
         k = 0;
         while (!f[6]) begin f = f << 1; k++; end
         f  = f << 1;
         de = 11'(896 - k);
      end
      return {imm[15], de, f, 45'd0};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Compare the outputs against the previous cycle's expectation, then drive new inputs.
   task automatic step(input logic v, input logic [31:0] w, input string tag);
      @(negedge clk);
      chk({e_tag, " strobe"}, 64'(out_wr), 64'(e_wr));
      chk({e_tag, " dest"}, 64'(out_rd), 64'(e_rd));
      chk({e_tag, " result"}, out_result, e_res);
      in_valid = v;
      in_insn  = w;
      e_tag    = tag;
      e_wr     = v && (w[31:26] == MAJ) && (w[5:1] == XO);
      if (e_wr) begin
         e_rd  = w[25:21];
         e_res = ref_dbl({w[15:6], w[20:16], w[0]});
      end
   endtask

   task automatic lit(input logic [15:0] imm, input logic [63:0] exp, input string tag);
      chk({tag, " model"}, ref_dbl(imm), exp);
      step(1'b1, mk(MAJ, XO, 5'd4, imm), tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 strobe", 64'(out_wr), 64'd0);
      chk("R8 result", out_result, 64'd0);
      chk("R8 dest", 64'(out_rd), 64'd0);
      rst_n = 1'b1;

      lit(16'h0000, 64'h0000_0000_0000_0000, "R2");
      lit(16'h8000, 64'h8000_0000_0000_0000, "R2");
      lit(16'h3F80, 64'h3FF0_0000_0000_0000, "R3");
      lit(16'hBFC0, 64'hBFF8_0000_0000_0000, "R3");
      lit(16'h3FFF, 64'h3FFF_E000_0000_0000, "R3");
      lit(16'h7F80, 64'h7FF0_0000_0000_0000, "R4");
      lit(16'hFF80, 64'hFFF0_0000_0000_0000, "R4");
      lit(16'h7FC0, 64'h7FF8_0000_0000_0000, "R4");
      lit(16'h0001, 64'h37A0_0000_0000_0000, "R5");
      lit(16'h8040, 64'hB800_0000_0000_0000, "R5");
      // R1 distinct field patterns: each immediate piece alone
      step(1'b1, mk(MAJ, XO, 5'd31, 16'h0001), "R1");
      step(1'b1, mk(MAJ, XO, 5'd17, 16'h003E), "R1");
      step(1'b1, mk(MAJ, XO, 5'd1,  16'hFFC0), "R1");
      // R7 near-miss opcodes and idle cycles: outputs must hold
      step(1'b1, mk(MAJ ^ 6'd1, XO, 5'd2, 16'h4000), "R7");
      step(1'b1, mk(MAJ, XO ^ 5'd16, 5'd3, 16'h4000), "R7");
      step(1'b0, mk(MAJ, XO, 5'd5, 16'h4000), "R7");
      // R9 back-to-back matching words
      step(1'b1, mk(MAJ, XO, 5'd6, 16'h4049), "R9");
      step(1'b1, mk(MAJ, XO, 5'd7, 16'hC2F7), "R9");
      step(1'b1, mk(MAJ, XO, 5'd8, 16'h0003), "R9");

      // R6 random stream mixing all cases
      for (int i = 0; i < 3000; i++) begin
         int          sel;
         logic [31:0] w;
         sel = int'($urandom % 8);
         w   = $urandom;
         if (sel < 5)       w = mk(MAJ, XO, w[25:21], w[15:0]);
         else if (sel == 5) w = mk(MAJ, XO, w[25:21], {w[15], 8'h00, w[6:0]});
         else if (sel == 6) w = mk(MAJ, XO ^ 5'(1 << (i % 5)), w[25:21], w[15:0]);
         step(($urandom % 6) != 0, w, (sel < 5) ? "R6" : (sel == 5) ? "R5" : "R7");
      end
      step(1'b0, '0, "R7");
      step(1'b0, '0, "R7");
      done = 1'b1;
   end

   initial begin
      void'($urandom(32'd20251));
      fork
         begin wait (done); end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule